// File: doc/BRIEF.md
# Dual-Thread Idle-State Coordinator

This block sits beside one processor core that runs two hardware threads. Each thread can ask to go idle in three ways: a halt event, a wait instruction that carries a target-depth hint, or a legacy I/O read of one of two processor level registers. The block keeps one idle state per thread and combines the two into the single state the core may actually use. Power-saving logic elsewhere must act on that combined state only, never on a request from one thread.

Idle states are ordered from shallow to deep: active (C0), C1, C3 and C6. The core takes the shallower of its two thread states. A thread that has gone idle accepts no further idle request until a wake returns it to active. Legacy level-register reads become the equivalent wait request only while redirection is enabled. When it is disabled, the read is handed back on a pass-through strobe so it can go out as a normal I/O read. When the enhanced-C1 feature is enabled, a core at C1 also raises an enhanced-C1 flag, provided every other active core in the package is at C1 or deeper.

Top module: `core_idle_arbiter`

## Requirements
- R1: On reset both thread states, the core state, the enhanced-C1 flag and the pass-through strobes are zero/active (state encoding 0=C0, 1=C1, 2=C3, 3=C6).
- R2: A thread in C0 that sees a halt, or a wait whose 2-bit hint is 0 (C1) or 3 (unsupported), is in C1 after the next clock edge.
- R3: A thread in C0 that sees a wait with hint 1 moves to C3, and with hint 2 moves to C6, after the next clock edge.
- R4: With redirection enabled, a level-register read by a thread in C0 moves it to C3 when the select bit is 0 and to C6 when it is 1; no pass-through strobe is raised.
- R5: With redirection disabled, a level-register read leaves the thread state unchanged and raises that thread's pass-through strobe in the same cycle.
- R6: A thread that is not in C0 ignores halt, wait and level-register requests.
- R7: A wake input returns its thread to C0 after the next clock edge and takes precedence over any request presented in the same cycle.
- R8: The core state equals the shallower of the two thread states and follows a thread change one clock edge later.
- R9: The enhanced-C1 flag is high exactly one edge after the enable was high, the shallower thread state was C1, and every other core was inactive or idle; it is low otherwise.
- R10: When a thread in C0 sees several requests at once, halt wins over wait, and wait wins over a level-register read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_req | input | 2 | Halt event per thread |
| wait_req | input | 2 | Wait instruction per thread |
| wait_hint | input | 4 | 2-bit depth hint per thread (thread 0 in bits 1:0) |
| lvl_rd | input | 2 | Level-register I/O read per thread |
| lvl_sel | input | 2 | Per thread: 0 = level-2 register, 1 = level-3 register |
| wake | input | 2 | Return-to-active per thread |
| redirect_en | input | 1 | Convert level-register reads into wait requests |
| c1e_en | input | 1 | Enable enhanced-C1 reporting |
| other_active | input | OTHER_CORES | Other cores that are in service |
| other_idle | input | OTHER_CORES | Other cores at C1 or deeper |
| thread_state | output | 4 | 2-bit state per thread |
| core_state | output | 2 | Resolved core state |
| core_c1e | output | 1 | Enhanced-C1 flag |
| io_passthru | output | 2 | Forward level-register read as plain I/O read |

## Verification
A wake and a fresh idle request can land on the same thread in the same cycle, and so can two idle requests of different kinds. The bench drives a wake together with a halt or a deep wait, both on an idle thread and on an active one. It expects the thread to be active after the edge. It also drives halt, wait and level reads together and expects the higher-priority request to set the state.

// File: rtl/core_idle_arbiter.sv
module core_idle_arbiter #(
  parameter int OTHER_CORES = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             halt_req,
  input  logic [1:0]             wait_req,
  input  logic [3:0]             wait_hint,
  input  logic [1:0]             lvl_rd,
  input  logic [1:0]             lvl_sel,
  input  logic [1:0]             wake,
  input  logic                   redirect_en,
  input  logic                   c1e_en,
  input  logic [OTHER_CORES-1:0] other_active,
  input  logic [OTHER_CORES-1:0] other_idle,
  output logic [3:0]             thread_state,
  output logic [1:0]             core_state,
  output logic                   core_c1e,
  output logic [1:0]             io_passthru
);
  localparam logic [1:0] ST_C0 = 2'd0;
  localparam logic [1:0] ST_C1 = 2'd1;
  localparam logic [1:0] ST_C3 = 2'd2;
  localparam logic [1:0] ST_C6 = 2'd3;

  for (genvar t = 0; t < 2; t++) begin : g_thr
    logic [1:0] st_q, hint_st, req_st;
    logic       req_v;

    assign hint_st = (wait_hint[2*t +: 2] == 2'd1) ? ST_C3 :
                     (wait_hint[2*t +: 2] == 2'd2) ? ST_C6 : ST_C1;

    always_comb begin
      req_v  = 1'b1;
      req_st = ST_C0;
      if (halt_req[t])                    req_st = ST_C1;
      else if (wait_req[t])               req_st = hint_st;
      else if (lvl_rd[t] && redirect_en)  req_st = lvl_sel[t] ? ST_C6 : ST_C3;
      else                                req_v  = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                          st_q <= ST_C0;
      else if (wake[t])                    st_q <= ST_C0;
      else if (st_q == ST_C0 && req_v)     st_q <= req_st;
    end

    assign thread_state[2*t +: 2] = st_q;
    assign io_passthru[t] = rst_n & lvl_rd[t] & ~redirect_en;
  end

  logic [1:0] shallow;
  logic       others_ok;

  assign shallow   = (thread_state[1:0] < thread_state[3:2]) ? thread_state[1:0] : thread_state[3:2];
  assign others_ok = &(other_idle | ~other_active);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_state <= ST_C0;
      core_c1e   <= 1'b0;
    end else begin
      core_state <= shallow;
      core_c1e   <= c1e_en & (shallow == ST_C1) & others_ok;
    end
  end
endmodule

// File: rtl/core_idle_arbiter_chk.sv
module core_idle_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] halt_req,
  input logic [1:0] wait_req,
  input logic [1:0] wake,
  input logic       c1e_en,
  input logic [3:0] thread_state,
  input logic [1:0] core_state,
  input logic       core_c1e
);
  for (genvar t = 0; t < 2; t++) begin : g_a
    a_r7_wake_to_c0: assert property (@(posedge clk) disable iff (!rst_n)
      wake[t] |=> thread_state[2*t +: 2] == 2'd0);
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (thread_state[2*t +: 2] != 2'd0 && !wake[t]) |=> $stable(thread_state[2*t +: 2]));
    a_r2_halt_c1: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_req[t] && !wake[t] && thread_state[2*t +: 2] == 2'd0) |=> thread_state[2*t +: 2] == 2'd1);
    a_r3_wait_leaves_c0: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_req[t] && !wake[t] && thread_state[2*t +: 2] == 2'd0) |=> thread_state[2*t +: 2] != 2'd0);
  end

  a_r8_core_shallow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (core_state <= $past(thread_state[1:0]) && core_state <= $past(thread_state[3:2])));
  a_r9_c1e_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_c1e) |-> $past(c1e_en));
  a_r9_c1e_at_c1: assert property (@(posedge clk) disable iff (!rst_n)
    core_c1e |-> core_state == 2'd1);
endmodule

bind core_idle_arbiter core_idle_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .wait_req(wait_req),
  .wake(wake), .c1e_en(c1e_en), .thread_state(thread_state),
  .core_state(core_state), .core_c1e(core_c1e)
);

// File: tb/test_core_idle_arbiter.sv
module test_core_idle_arbiter;
  logic clk = 0, rst_n = 0;
  logic [1:0] halt = 0, wt = 0, lvl = 0, sel = 0, wake = 0, pass;
  logic [3:0] hint = 0, ts;
  logic redir = 0, c1en = 0, c1e;
  logic [2:0] oact = 0, oidle = 0;
  logic [1:0] core;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  core_idle_arbiter #(.OTHER_CORES(3)) i_core_idle_arbiter (
    .clk(clk), .rst_n(rst_n), .halt_req(halt), .wait_req(wt), .wait_hint(hint),
    .lvl_rd(lvl), .lvl_sel(sel), .wake(wake), .redirect_en(redir), .c1e_en(c1e_en_w),
    .other_active(oact), .other_idle(oidle), .thread_state(ts), .core_state(core),
    .core_c1e(c1e), .io_passthru(pass));
  logic c1e_en_w;
  assign c1e_en_w = c1en;

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic clr();
    halt = 0; wt = 0; lvl = 0; wake = 0; hint = 0; sel = 0;
  endtask

  task automatic wake_all();
    clr(); wake = 2'b11; step(); clr(); step();
  endtask

  function automatic int th(int t);
    return int'(ts[2*t +: 2]);
  endfunction

  task automatic t_reset();
    rst_n = 0; step(); step();
    chk("R1 thread0", th(0), 0); chk("R1 thread1", th(1), 0);
    chk("R1 core", core, 0); chk("R1 c1e", c1e, 0); chk("R1 pass", pass, 0);
    rst_n = 1; step();
    chk("R1 after release", ts, 0);
  endtask

  task automatic t_c1();
    clr(); halt[0] = 1; step(); clr();
    chk("R2 halt", th(0), 1); chk("R2 other thread", th(1), 0);
    wake_all();
    wt[1] = 1; hint[3:2] = 2'd3; step(); clr();
    chk("R2 hint unsupported", th(1), 1);
    wake_all();
    wt[0] = 1; hint[1:0] = 2'd0; step(); clr();
    chk("R2 hint C1", th(0), 1);
    wake_all();
  endtask

  task automatic t_deep();
    wt = 2'b11; hint = {2'd2, 2'd1}; step(); clr();
    chk("R3 hint C3", th(0), 2); chk("R3 hint C6", th(1), 3);
    chk("R8 latency", core, 0);
    step();
    chk("R8 C3+C6", core, 2);
    wake_all();
  endtask

  task automatic t_legacy();
    redir = 1; lvl = 2'b11; sel = 2'b10;
    #1 chk("R4 no pass", pass, 0);
    step(); clr();
    chk("R4 level2", th(0), 2); chk("R4 level3", th(1), 3);
    wake_all();
    redir = 0; lvl[0] = 1;
    #1 chk("R5 pass t0", pass, 1);
    step(); clr();
    chk("R5 state kept", ts, 0);
    lvl[1] = 1; sel[1] = 1;
    #1 chk("R5 pass t1", pass, 2);
    step(); clr();
    chk("R5 state kept t1", ts, 0);
  endtask

  task automatic t_ignore();
    halt[0] = 1; step(); clr();
    wt[0] = 1; hint[1:0] = 2'd2; step(); clr();
    chk("R6 wait ignored", th(0), 1);
    redir = 1; lvl[0] = 1; sel[0] = 1; step(); clr();
    chk("R6 level ignored", th(0), 1);
    halt[0] = 1; step(); clr();
    chk("R6 halt ignored", th(0), 1);
    redir = 0;
    wake_all();
  endtask

  task automatic t_wake_race();
    halt[0] = 1; step(); clr();
    wake[0] = 1; halt[0] = 1; step(); clr();
    chk("R7 wake over halt while idle", th(0), 0);
    wake[1] = 1; wt[1] = 1; hint[3:2] = 2'd2; step(); clr();
    chk("R7 wake over wait in C0", th(1), 0);
    step();
    chk("R7 core active", core, 0);
  endtask

  task automatic t_resolve();
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        int exp;
        clr();
        if (a != 0) begin wt[0] = 1; hint[1:0] = 2'(a - 1); end
        if (b != 0) begin wt[1] = 1; hint[3:2] = 2'(b - 1); end
        step(); clr();
        chk("R8 thread0 set", th(0), a); chk("R8 thread1 set", th(1), b);
        step();
        exp = (a < b) ? a : b;
        chk("R8 shallowest", core, exp);
        wake_all();
      end
    end
  endtask

  task automatic t_c1e();
    halt = 2'b11; step(); clr();
    c1en = 1; oact = 3'b101; oidle = 3'b001; step();
    chk("R9 active core busy", c1e, 0);
    oidle = 3'b101; step();
    chk("R9 all idle", c1e, 1); chk("R9 core C1", core, 1);
    c1en = 0; step();
    chk("R9 disabled", c1e, 0);
    c1en = 1; step();
    chk("R9 reenabled", c1e, 1);
    wake_all();
    chk("R9 core C0", c1e, 0);
    wt = 2'b11; hint = {2'd1, 2'd1}; step(); clr(); step();
    chk("R9 deeper core", c1e, 0);
    c1en = 0; wake_all();
  endtask

  task automatic t_prio();
    redir = 1;
    halt[0] = 1; wt[0] = 1; hint[1:0] = 2'd2; lvl[0] = 1; sel[0] = 1; step(); clr();
    chk("R10 halt first", th(0), 1);
    wt[1] = 1; hint[3:2] = 2'd2; lvl[1] = 1; sel[1] = 0; step(); clr();
    chk("R10 wait over level", th(1), 3);
    redir = 0; wake_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_c1();
    t_deep();
    t_legacy();
    t_ignore();
    t_wake_race();
    t_resolve();
    t_c1e();
    t_prio();
    finish_run();
  end
endmodule